// File: doc/BRIEF.md
# Serial Absolute Encoder Receive Channel

This block runs one channel of a request/response link to a serial absolute position encoder. A start pulse makes it raise the transmit line for a programmable number of clock cycles. After that request it waits for the encoder's start bit. It then samples a programmable number of data bits, least significant first, at a bit rate set by a 20-bit phase accumulator. The received frame ends up left-justified across two 32-bit words and one 12-bit word.

The receive line first passes through a two-flop synchronizer and then a saturating-counter glitch filter of programmable length. The block reports three status outputs: busy, receive-active, and a cable-error flag. The cable-error flag is raised when the line sat at the wrong level for the whole idle time before a request. The four setup fields (request length, frame length, bit-rate increment, filter length) only change when a write strobe arrives while the setup unlock input is high. Their reset defaults come from the clock frequency parameter: an 8 µs request, 76 bits, 1.024 MHz and a filter length of 15.

Top module: `enc_rx_channel`

## Requirements
- R1: After reset the following outputs are 0: tx_o, busy_o, rx_active_o, cable_err_o and all three data words. The setup fields hold their defaults: request length round-down(CLK_KHZ·REQ_NS/10^6) (800 at 100 MHz), frame length 76, bit-rate increment round(2^20·BIT_KHZ/CLK_KHZ) (10737), filter length 15.
- R2: A start_i pulse sampled while busy_o is 0 raises tx_o from the next cycle for exactly the programmed request length (a value of 0 acts as 1). A start_i pulse sampled while busy_o is 1 is ignored.
- R3: busy_o rises together with tx_o. It falls on the cycle after the last data bit is sampled, in the same cycle as rx_active_o. rx_active_o is high only after the request has ended, so tx_o and rx_active_o are never both 1.
- R4: The line idles at 1. After the request, the first filtered 0 is the start bit. At that point the accumulator is preloaded to 2^19. Each cycle it adds the increment, and every carry out of bit 19 is a bit tick. The first tick (the middle of the start bit) is skipped. The next N ticks sample the N data bits.
- R5: Each sampled bit enters bit 75 of a 76-bit register, which shifts towards bit 0. word0_o holds register bits 31..0, word1_o holds bits 63..32, and word2_o holds bits 75..64. For a 76-bit frame, frame bit i lands in register bit i. For a shorter frame of N bits, the first bit lands in register bit 76−N and the older contents move down by N.
- R6: The data words change only while rx_active_o is 1.
- R7: The filter output changes only after the synchronized input has held its new level long enough to walk the counter from one end to the other (filter length counts; 0 acts as 1). A pulse shorter than the filter length leaves the sampled data unchanged.
- R8: A cfg_wr_i strobe with setup_en_i = 1 loads all four setup fields. With setup_en_i = 0 the strobe changes nothing.
- R9: At each accepted start, cable_err_o becomes 1 if the filtered line was 0 on every idle cycle since the previous transfer (or since reset). Otherwise it becomes 0.
- R10: With the default increment, the receive phase lasts 76.5 bit periods of 2^20/increment cycles each, within ±2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle transfer start |
| rx_i | input | 1 | Serial line from the encoder (idle 1) |
| tx_o | output | 1 | Request line to the encoder |
| cfg_wr_i | input | 1 | Setup write strobe |
| setup_en_i | input | 1 | Setup unlock; writes take effect only when 1 |
| cfg_req_len_i | input | 10 | Request length in clock cycles |
| cfg_bit_len_i | input | 7 | Data bits per frame |
| cfg_rate_i | input | 20 | Phase accumulator increment |
| cfg_filt_i | input | 4 | Filter length in clock cycles |
| busy_o | output | 1 | Transfer in progress |
| rx_active_o | output | 1 | Start bit seen, data bits being taken |
| cable_err_o | output | 1 | Line was at the non-idle level through the previous idle time |
| word0_o | output | 32 | Frame register bits 31..0 |
| word1_o | output | 32 | Frame register bits 63..32 |
| word2_o | output | 12 | Frame register bits 75..64 |

## Verification
The assertions check the following on every cycle:
- the ordering among tx_o, busy_o and rx_active_o;
- that tx_o only rises after an accepted start;
- that the data words are frozen outside reception;
- that a locked setup write leaves the configuration untouched.

Only the bench scenarios can show the rest: the request length actually measured and the packing of bits across the three words for long and short frames. They also cover glitch rejection by the filter, the cable-error decision made from the idle line, and the length of the receive phase produced by the default increment.

// File: rtl/enc_rx_pkg.sv
package enc_rx_pkg;
  localparam int ACC_W  = 20;
  localparam int REQ_W  = 10;
  localparam int LEN_W  = 7;
  localparam int FILT_W = 4;

  typedef struct packed {
    logic [REQ_W-1:0]  req_len;
    logic [LEN_W-1:0]  bit_len;
    logic [ACC_W-1:0]  rate;
    logic [FILT_W-1:0] filt;
  } enc_cfg_t;

  // increment = round(2^ACC_W * bit rate / clock rate)
  function automatic logic [ACC_W-1:0] phase_inc(input longint clk_khz, input longint bit_khz);
    longint num;
    num = (longint'(1) << ACC_W) * bit_khz + clk_khz / 2;
    return ACC_W'(num / clk_khz);
  endfunction

  // request length in clock cycles for a width given in ns
  function automatic logic [REQ_W-1:0] req_cycles(input longint clk_khz, input longint ns);
    return REQ_W'((clk_khz * ns) / 64'd1000000);
  endfunction

  // zero is not a usable filter length; treat it as one
  function automatic logic [FILT_W-1:0] filt_eff(input logic [FILT_W-1:0] f);
    return (f == '0) ? FILT_W'(1) : f;
  endfunction
endpackage

// File: rtl/enc_setup_regs.sv
module enc_setup_regs
  import enc_rx_pkg::*;
#(
  parameter enc_cfg_t DEF_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  logic     unlock_i,
  input  enc_cfg_t wdata_i,
  output enc_cfg_t cfg_o
);
  logic wr_take;
  assign wr_take = wr_i & unlock_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_o <= DEF_CFG;
    else if (wr_take) cfg_o <= wdata_i;
  end
endmodule

// File: rtl/enc_rx_filter.sv
module enc_rx_filter
  import enc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_i,
  input  logic [FILT_W-1:0] len_i,
  output logic              filt_o
);
  logic [1:0]        sync_q;
  logic [FILT_W-1:0] cnt_q, cnt_nx, len;

  assign len = filt_eff(len_i);

  always_comb begin
    if (sync_q[1])
      cnt_nx = (cnt_q < len) ? cnt_q + FILT_W'(1) : len;
    else if (cnt_q == '0)
      cnt_nx = '0;
    else
      cnt_nx = (cnt_q > len) ? len - FILT_W'(1) : cnt_q - FILT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '1;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      cnt_q  <= cnt_nx;
      if (cnt_nx == len)     filt_o <= 1'b1;
      else if (cnt_nx == '0) filt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/enc_bit_timer.sv
module enc_bit_timer
  import enc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             preload_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign tick_o = run_i & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)         acc_q <= '0;
    else if (preload_i) acc_q <= HALF;
    else if (run_i)     acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/enc_rx_channel.sv
module enc_rx_channel
  import enc_rx_pkg::*;
#(
  parameter int CLK_KHZ  = 100000,
  parameter int BIT_KHZ  = 1024,
  parameter int REQ_NS   = 8000,
  parameter int FRAME_W  = 76,
  parameter int DEF_FILT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               rx_i,
  output logic               tx_o,
  input  logic               cfg_wr_i,
  input  logic               setup_en_i,
  input  logic [REQ_W-1:0]   cfg_req_len_i,
  input  logic [LEN_W-1:0]   cfg_bit_len_i,
  input  logic [ACC_W-1:0]   cfg_rate_i,
  input  logic [FILT_W-1:0]  cfg_filt_i,
  output logic               busy_o,
  output logic               rx_active_o,
  output logic               cable_err_o,
  output logic [31:0]        word0_o,
  output logic [31:0]        word1_o,
  output logic [FRAME_W-65:0] word2_o
);
  localparam enc_cfg_t DEF_CFG = '{
    req_len: req_cycles(CLK_KHZ, REQ_NS),
    bit_len: LEN_W'(FRAME_W),
    rate:    phase_inc(CLK_KHZ, BIT_KHZ),
    filt:    FILT_W'(DEF_FILT)
  };

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_RECV} state_t;

  state_t             state_q;
  enc_cfg_t           cfg_q, cfg_wdata;
  logic [REQ_W-1:0]   req_cnt_q;
  logic [LEN_W-1:0]   bit_cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               skip_q, low_all_q;
  logic               line_f;

  // named internal events
  logic start_take, req_done, start_bit_seen, bit_tick, data_tick, last_bit;

  assign cfg_wdata = '{req_len: cfg_req_len_i, bit_len: cfg_bit_len_i,
                       rate: cfg_rate_i, filt: cfg_filt_i};

  enc_setup_regs #(.DEF_CFG(DEF_CFG)) i_setup (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .unlock_i(setup_en_i),
    .wdata_i(cfg_wdata), .cfg_o(cfg_q));

  enc_rx_filter i_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(rx_i), .len_i(cfg_q.filt), .filt_o(line_f));

  enc_bit_timer i_timer (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == S_RECV),
    .preload_i(start_bit_seen), .inc_i(cfg_q.rate), .tick_o(bit_tick));

  assign start_take     = (state_q == S_IDLE) && start_i;
  assign req_done       = (state_q == S_REQ) &&
                          ({1'b0, req_cnt_q} + 1'b1 >= {1'b0, cfg_q.req_len});
  assign start_bit_seen = (state_q == S_WAIT) && !line_f;
  assign data_tick      = bit_tick && !skip_q;
  assign last_bit       = data_tick && (LEN_W'(bit_cnt_q + 1'b1) == cfg_q.bit_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      req_cnt_q   <= '0;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      skip_q      <= 1'b0;
      low_all_q   <= 1'b1;
      cable_err_o <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (line_f) low_all_q <= 1'b0;
          if (start_take) begin
            state_q     <= S_REQ;
            req_cnt_q   <= '0;
            cable_err_o <= low_all_q && !line_f;
            low_all_q   <= 1'b1;
          end
        end
        S_REQ: begin
          req_cnt_q <= req_cnt_q + 1'b1;
          if (req_done) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (start_bit_seen) begin
            state_q   <= S_RECV;
            bit_cnt_q <= '0;
            skip_q    <= 1'b1;
          end
        end
        S_RECV: begin
          if (bit_tick) skip_q <= 1'b0;
          if (data_tick) begin
            shreg_q   <= {line_f, shreg_q[FRAME_W-1:1]};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (last_bit) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_o        = (state_q == S_REQ);
  assign busy_o      = (state_q != S_IDLE);
  assign rx_active_o = (state_q == S_RECV);
  assign word0_o     = shreg_q[31:0];
  assign word1_o     = shreg_q[63:32];
  assign word2_o     = shreg_q[FRAME_W-1:64];
endmodule

// File: rtl/enc_rx_channel_chk.sv
module enc_rx_channel_chk
  import enc_rx_pkg::*;
#(
  parameter int FRAME_W = 76
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               tx_o,
  input logic               busy_o,
  input logic               rx_active_o,
  input logic               cfg_wr_i,
  input logic               setup_en_i,
  input enc_cfg_t           cfg_q,
  input logic [31:0]        word0_o,
  input logic [31:0]        word1_o,
  input logic [FRAME_W-65:0] word2_o
);
  // R3: request and reception both sit inside busy and never overlap
  p_tx_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_o |-> busy_o);
  p_rx_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active_o |-> busy_o && !tx_o);
  p_busy_ends_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(rx_active_o));

  // R2: a request starts only from an accepted start pulse
  p_tx_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_o) |-> $past(start_i) && !$past(busy_o));

  // R6: data words frozen outside reception
  p_words_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active_o |=> $stable(word0_o) && $stable(word1_o) && $stable(word2_o));

  // R8: setup fields hold unless an unlocked write arrives
  p_setup_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_i && setup_en_i) |=> $stable(cfg_q));
endmodule

bind enc_rx_channel enc_rx_channel_chk #(.FRAME_W(FRAME_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_o(tx_o), .busy_o(busy_o),
  .rx_active_o(rx_active_o), .cfg_wr_i(cfg_wr_i), .setup_en_i(setup_en_i),
  .cfg_q(cfg_q), .word0_o(word0_o), .word1_o(word1_o), .word2_o(word2_o));

// File: tb/test_enc_rx_channel.sv
module test_enc_rx_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rx_i = 1'b1, cfg_wr_i = 1'b0, setup_en_i = 1'b0;
  logic [9:0]  cfg_req_len_i = '0;
  logic [6:0]  cfg_bit_len_i = '0;
  logic [19:0] cfg_rate_i = '0;
  logic [3:0]  cfg_filt_i = '0;
  logic tx_o, busy_o, rx_active_o, cable_err_o;
  logic [31:0] word0_o, word1_o;
  logic [11:0] word2_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  int req_model = 800;   // R1 default request length at 100 MHz
  int rem = 0;
  logic [75:0] exp_frame = '0;
  int act_cycles = 0;
  bit rx_seen = 0;

  always #2 clk = ~clk;   // 250 MHz

  enc_rx_channel i_enc_rx_channel (.*);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // per-clock reference for the request line, taken just after each falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check("R2 tx_o per cycle", tx_o, rem > 0);
      check("R3 tx/rx_active overlap", tx_o && rx_active_o, 0);
      if (rx_active_o) begin act_cycles++; rx_seen = 1; end
      if (rem > 0) rem--;
      if (start_i && !busy_o) rem = (req_model == 0) ? 1 : req_model;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic write_cfg(input bit en, input int req, input int bl, input int rate, input int filt);
    @(negedge clk);
    setup_en_i = en; cfg_req_len_i = 10'(req); cfg_bit_len_i = 7'(bl);
    cfg_rate_i = 20'(rate); cfg_filt_i = 4'(filt); cfg_wr_i = 1'b1;
    @(negedge clk); cfg_wr_i = 1'b0; setup_en_i = 1'b0;
    if (en) req_model = req;
  endtask

  task automatic wait_req_end();
    while (!tx_o) @(negedge clk);
    while (tx_o) @(negedge clk);
  endtask

  // encoder answering with a held-low line: start bit and all-zero data
  task automatic low_answer(input int n);
    wait_req_end();
    rx_i = 1'b0;
    for (int i = 0; i < n; i++) exp_frame = {1'b0, exp_frame[75:1]};
    while (busy_o) @(negedge clk);
  endtask

  task automatic send_frame(input logic [75:0] bits, input int n, input int per, input bit glitch);
    wait_req_end();
    repeat (10) @(negedge clk);
    rx_i = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      exp_frame = {bits[i], exp_frame[75:1]};
      for (int c = 0; c < per; c++) begin
        rx_i = (glitch && c == per / 2) ? ~bits[i] : bits[i];
        @(negedge clk);
      end
    end
    rx_i = 1'b1;
    while (busy_o) @(negedge clk);
  endtask

  task automatic check_words(input string req);
    check({req, " word0"}, word0_o, exp_frame[31:0]);
    check({req, " word1"}, word1_o, exp_frame[63:32]);
    check({req, " word2"}, word2_o, exp_frame[75:64]);
  endtask

  initial begin
    logic [75:0] pat_a;
    real bit_cyc, want;
    pat_a = {12'hA5C, 32'h3E91_720F, 32'hED4B_6837};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_o", tx_o, 0);
    check("R1 busy_o", busy_o, 0);
    check("R1 rx_active_o", rx_active_o, 0);
    check("R1 cable_err_o", cable_err_o, 0);
    check_words("R1");
    repeat (30) @(negedge clk);

    // R1/R10 default request length (per-cycle model) and default bit timing
    act_cycles = 0; rx_seen = 0;
    pulse_start();
    check("R3 busy after start", busy_o, 1);
    low_answer(76);
    check("R3 rx_active seen", rx_seen, 1);
    check("R3 rx_active low at end", rx_active_o, 0);
    bit_cyc = 1048576.0 / 10737.0;
    want = 76.5 * bit_cyc;
    check("R10 receive duration in range",
          (act_cycles >= int'(want) - 2) && (act_cycles <= int'(want) + 2), 1);
    check_words("R5 zero frame");
    check("R9 line high before request", cable_err_o, 0);

    // R8 locked write ignored; R9 line held low in idle
    repeat (40) @(negedge clk);
    write_cfg(0, 20, 12, 26215, 3);
    pulse_start();
    check("R9 cable error on low idle line", cable_err_o, 1);
    low_answer(76);   // R8: still 800-cycle request, 76 bits
    check_words("R8 frame length unchanged");
    rx_i = 1'b1;
    repeat (40) @(negedge clk);

    // R8 unlocked write; R4/R5 full frame; R2 start while busy ignored
    write_cfg(1, 20, 76, 26215, 3);
    fork
      begin pulse_start(); send_frame(pat_a, 76, 40, 0); end
      begin repeat (600) @(negedge clk); pulse_start(); end
    join
    check("R9 cable error cleared", cable_err_o, 0);
    check_words("R5 76-bit frame");
    check("R2 no second request", busy_o, 0);

    // R5 short frame left-justified; R7 glitches rejected
    write_cfg(1, 20, 12, 26215, 3);
    pulse_start();
    send_frame({64'h0, 12'hC93}, 12, 40, 1);
    check_words("R7 R5 12-bit frame with glitches");

    // R6 idle line activity leaves the words alone
    for (int k = 0; k < 6; k++) begin
      rx_i = ~rx_i;
      repeat (7) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (20) @(negedge clk);
    check_words("R6 idle toggling");
    check("R6 still idle", busy_o, 0);

    summary();
  end
endmodule